// File: doc/BRIEF.md
# Serial EEPROM Word Fetcher

This block fetches one 16-bit word from a three-wire serial EEPROM. A one-cycle start strobe with a word address begins a read. The block then drives the shared serial lines: chip select, serial clock and serial data towards the memory. It samples the data line coming back from the memory. When the read is complete it presents the word and raises a one-cycle completion pulse.

Several devices share the same serial lines. For that reason the block also drives a device-select code for the whole transaction, so that only the EEPROM answers. Each frame has three parts: a four-bit read command, six address bits, and sixteen data bits clocked in. The serial clock comes from the system clock through a parameterised half-period divider. The two bytes of the received word are exchanged before the word is returned.

Top module: `mwr_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sck`, `ee_sdo`, `dev_sel` and `rd_done` are all 0.
- R2: `dev_sel` carries the parameter `DEV_CODE` (default 5) for as long as `ee_cs` is high, and is 0 otherwise. While `ee_sck` is high, `ee_cs` is high. In the cycle `rd_done` is high, `ee_cs`, `ee_sck` and `dev_sel` are already 0.
- R3: The first four bits the memory samples on rising `ee_sck` edges are 0, 1, 1, 0, in that order.
- R4: The next six sampled bits are bits 5 down to 1 and then bit 0 of `addr_in`, most significant first. Bits of `addr_in` above bit 5 have no effect.
- R5: `ee_sdo` changes only while `ee_sck` is low.
- R6: After the address, sixteen bits are taken from `ee_sdi` while `ee_sck` is high, most significant bit first. The memory places each bit after a falling edge.
- R7: `rd_data` equals the received word with its two bytes exchanged (received bits 7..0 in `rd_data[15:8]`). It is valid from the cycle of a single-cycle `rd_done` pulse.
- R8: Every high phase of `ee_sck` lasts exactly `HALF_DIV` system clock cycles.
- R9: A start strobe that arrives while a read is in progress is ignored. A start strobe in the cycle `rd_done` is high begins a new read.
- R10: Each read produces exactly 26 rising edges of `ee_sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Read request strobe, accepted when idle |
| addr_in | input | AIN_W | Word address; only bits 5..0 are used |
| ee_cs | output | 1 | Serial chip select, high during a read |
| ee_sck | output | 1 | Serial clock |
| ee_sdo | output | 1 | Serial data towards the memory |
| ee_sdi | input | 1 | Serial data from the memory |
| dev_sel | output | DEV_W | Device-select code, `DEV_CODE` during a read |
| rd_data | output | 16 | Byte-swapped word read |
| rd_done | output | 1 | One-cycle completion pulse |

## Verification
The completion of one read and the acceptance of the next start strobe can fall in the same cycle. The bench provokes this by raising `start` in the cycle where it sees `rd_done`. It then expects a full second frame, with its own address and data, and no lost or merged transaction. A strobe given in the middle of a frame must leave that frame's captured address and returned word untouched, and must not queue a second read.

// File: rtl/mwr_pkg.sv
`timescale 1ns/1ps
package mwr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PREP,
        PH_OUT_LO,
        PH_OUT_HI,
        PH_IN_LO,
        PH_IN_HI,
        PH_TAIL
    } phase_t;

    localparam int CMD_W   = 4;
    localparam logic [CMD_W-1:0] CMD_READ = 4'b0110;
    localparam int WADDR_W = 6;
    localparam int WORD_W  = 16;
endpackage

// File: rtl/mwr_tick.sv
`timescale 1ns/1ps
module mwr_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en)
            s_d.cnt = '0;
        else if (s_q.cnt == LAST)
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = en && (s_q.cnt == LAST);

    initial assert (HALF_DIV >= 2) else $error("HALF_DIV must be at least 2");

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R8
endmodule

// File: rtl/mwr_seq.sv
`timescale 1ns/1ps
module mwr_seq
    import mwr_pkg::*;
#(
    parameter int AIN_W    = 8,
    parameter int DEV_W    = 3,
    parameter logic [DEV_W-1:0] DEV_CODE = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AIN_W-1:0]  addr_in,
    input  logic              tick,
    input  logic              sdi,
    output logic              busy,
    output logic              cs,
    output logic              sck,
    output logic              sdo,
    output logic [DEV_W-1:0]  dev_sel,
    output logic [WORD_W-1:0] word_raw,
    output logic              done
);
    localparam int TX_W  = CMD_W + WADDR_W;
    localparam int BC_W  = $clog2(WORD_W + 1);
    localparam logic [BC_W-1:0] TX_LAST = BC_W'(TX_W - 1);
    localparam logic [BC_W-1:0] RX_LAST = BC_W'(WORD_W - 1);

    typedef struct packed {
        phase_t              phase;
        logic [BC_W-1:0]     bits;
        logic [TX_W-1:0]     tx;
        logic [WORD_W-1:0]   rx;
        logic [WORD_W-1:0]   word;
        logic                done;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_PREP;
                    s_d.bits  = '0;
                    s_d.tx    = {CMD_READ, addr_in[WADDR_W-1:0]};
                end
            end
            PH_PREP:   if (tick) s_d.phase = PH_OUT_LO;
            PH_OUT_LO: if (tick) s_d.phase = PH_OUT_HI;
            PH_OUT_HI: begin
                if (tick) begin
                    if (s_q.bits == TX_LAST) begin
                        s_d.phase = PH_IN_LO;
                        s_d.bits  = '0;
                    end else begin
                        s_d.phase = PH_OUT_LO;
                        s_d.bits  = s_q.bits + 1'b1;
                        s_d.tx    = {s_q.tx[TX_W-2:0], 1'b0};
                    end
                end
            end
            PH_IN_LO:  if (tick) s_d.phase = PH_IN_HI;
            PH_IN_HI: begin
                if (tick) begin
                    s_d.rx = {s_q.rx[WORD_W-2:0], sdi};
                    if (s_q.bits == RX_LAST) begin
                        s_d.phase = PH_TAIL;
                    end else begin
                        s_d.phase = PH_IN_LO;
                        s_d.bits  = s_q.bits + 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                if (tick) begin
                    s_d.phase = PH_IDLE;
                    s_d.word  = s_q.rx;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.phase != PH_IDLE);
    assign cs       = busy;
    assign sck      = (s_q.phase == PH_OUT_HI) || (s_q.phase == PH_IN_HI);
    assign sdo      = ((s_q.phase == PH_OUT_LO) || (s_q.phase == PH_OUT_HI)) ? s_q.tx[TX_W-1] : 1'b0;
    assign dev_sel  = busy ? DEV_CODE : '0;
    assign word_raw = s_q.word;
    assign done     = s_q.done;

    AST_SCK_WITHIN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> cs); // R2
    AST_SDO_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cs && !sck && dev_sel == '0)); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !$past(cs) && $past(start)) |=> (cs || done)); // R9
endmodule

// File: rtl/mwr_swap.sv
`timescale 1ns/1ps
module mwr_swap #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
    end
endmodule

// File: rtl/mwr_reader.sv
`timescale 1ns/1ps
module mwr_reader
    import mwr_pkg::*;
#(
    parameter int AIN_W    = 8,
    parameter int HALF_DIV = 4,
    parameter int DEV_W    = 3,
    parameter logic [DEV_W-1:0] DEV_CODE = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AIN_W-1:0]  addr_in,
    output logic              ee_cs,
    output logic              ee_sck,
    output logic              ee_sdo,
    input  logic              ee_sdi,
    output logic [DEV_W-1:0]  dev_sel,
    output logic [15:0]       rd_data,
    output logic              rd_done
);
    logic busy, tick;
    logic [WORD_W-1:0] word_raw;

    mwr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    mwr_seq #(.AIN_W(AIN_W), .DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr_in (addr_in),
        .tick    (tick),
        .sdi     (ee_sdi),
        .busy    (busy),
        .cs      (ee_cs),
        .sck     (ee_sck),
        .sdo     (ee_sdo),
        .dev_sel (dev_sel),
        .word_raw(word_raw),
        .done    (rd_done)
    );

    mwr_swap #(.W(WORD_W)) u_swap (
        .din (word_raw),
        .dout(rd_data)
    );

    AST_DEVSEL_MATCHES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> (dev_sel == DEV_CODE)); // R2
endmodule

// File: tb/mwr_reader_test.sv
`timescale 1ns/1ps
module mwr_reader_test;
    localparam int HALF = 4;
    localparam logic [2:0] CODE = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] addr_in = '0;
    logic ee_cs, ee_sck, ee_sdo;
    logic ee_sdi = 1'b0;
    logic [2:0] dev_sel;
    logic [15:0] rd_data;
    logic rd_done;

    always #2.5 clk = ~clk;

    mwr_reader #(.AIN_W(8), .HALF_DIV(HALF), .DEV_W(3), .DEV_CODE(CODE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
        .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_sdo(ee_sdo), .ee_sdi(ee_sdi),
        .dev_sel(dev_sel), .rd_data(rd_data), .rd_done(rd_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [5:0] a);
        logic [15:0] p;
        p = 16'(a * 16'h9E37);
        return p ^ 16'h5AC3;
    endfunction

    // behavioural memory
    int rises = 0;
    logic [9:0] cap = '0;
    logic [15:0] cur_word = '0;
    always @(posedge ee_cs) begin
        rises = 0;
        cap = '0;
    end
    always @(posedge ee_sck) if (ee_cs) begin
        if (rises < 10) cap = {cap[8:0], ee_sdo};
        rises++;
    end
    always @(negedge ee_sck) if (ee_cs && rises >= 10 && rises < 26) begin
        if (rises == 10) cur_word = mem_word(cap[5:0]);
        ee_sdi = cur_word[15 - (rises - 10)];
    end

    // pin-rule monitors
    int sdo_bad = 0, hi_bad = 0, sel_bad = 0, hi_run = 0;
    always @(ee_sdo) if (ee_sck) sdo_bad++;          // R5
    always @(negedge clk) begin
        if (ee_sck) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != HALF) hi_bad++;            // R8
            hi_run = 0;
        end
        if (ee_cs ? (dev_sel != CODE) : (dev_sel != 3'd0)) sel_bad++; // R2
    end

    typedef struct { logic [5:0] a; } exp_t;
    exp_t q[$];

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rd_done) begin
                exp_t e;
                logic [15:0] w;
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected completion", 1, 0);
                end else begin
                    e = q.pop_front();
                    w = mem_word(e.a);
                    chk(rises == 26, "R10 sck rising edges", rises, 26);
                    chk(cap[9:6] == 4'b0110, "R3 command bits", cap[9:6], 4'b0110);
                    chk(cap[5:0] == e.a, "R4 address bits", cap[5:0], e.a);
                    chk(rd_data == {w[7:0], w[15:8]}, "R6 R7 swapped word", rd_data, {w[7:0], w[15:8]});
                    chk(!ee_cs && !ee_sck && dev_sel == 0, "R2 lines idle at done",
                        {ee_cs, ee_sck, dev_sel}, 0);
                end
                @(negedge clk);
                chk(!rd_done, "R7 done single cycle", rd_done, 0);
            end
        end
    end

    task automatic issue(input logic [7:0] a);
        @(negedge clk);
        while (ee_cs) @(negedge clk);
        q.push_back('{a: a[5:0]});
        addr_in = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0 || ee_cs) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(ee_cs == 0, "R1 cs at reset", ee_cs, 0);
        chk(ee_sck == 0, "R1 sck at reset", ee_sck, 0);
        chk(ee_sdo == 0, "R1 sdo at reset", ee_sdo, 0);
        chk(dev_sel == 0, "R1 dev_sel at reset", dev_sel, 0);
        chk(rd_done == 0, "R1 done at reset", rd_done, 0);
        rst_n = 1'b1;

        issue(8'h00); drain();
        issue(8'h3F); drain();
        issue(8'h2A); drain();
        issue(8'h15); drain();
        issue(8'hC5); drain();                       // R4 upper bits masked

        // R9: strobe mid-frame is ignored
        issue(8'h09);
        repeat (40) @(negedge clk);
        addr_in = 8'h33; start = 1'b1;
        @(negedge clk); start = 1'b0;
        drain();
        chk(!ee_cs, "R9 no extra read after busy strobe", ee_cs, 0);

        // R9: strobe in the done cycle starts a new read
        issue(8'h1C);
        @(negedge clk);
        while (!rd_done) @(negedge clk);
        q.push_back('{a: 6'h27});
        addr_in = 8'h27; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(ee_cs, "R9 read accepted on done cycle", ee_cs, 1);
        drain();

        chk(sdo_bad == 0, "R5 sdo changes while sck high", sdo_bad, 0);
        chk(hi_bad == 0, "R8 sck high width", hi_bad, 0);
        chk(sel_bad == 0, "R2 dev_sel tracking cs", sel_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule